// File: doc/BRIEF.md
# External Data Memory Address Router

This block takes each data-move request from a small processor core and decides where it goes. The target is either the on-chip data RAM or an external parallel address bus. A request comes with a flag that picks 8-bit or 16-bit pointer addressing. With 8-bit pointers, the effective address is built from a page register (high byte) and a register-pointer byte (low byte). With 16-bit pointers, the full data pointer is the effective address.

A two-bit mode input selects one of two routings:

- **Internal-only:** every access lands in the on-chip RAM. The address wraps modulo the RAM size.
- **Split:** the space is divided at the RAM size. Accesses below the boundary stay on chip and the rest go out on the bus.

In split mode, an 8-bit pointer access that goes off chip drives only the low address byte. This lets port latches supply the upper byte. A 16-bit access drives all sixteen lines.

All outputs are registered. A request sampled high on a clock edge is answered on the following cycle with a one-cycle acknowledge, together with the routing result for that request.

Top module: `xdataRouter`

## Requirements
- R1: A request sampled with `req` high produces `ack` high for exactly the next cycle. A cycle without a request leaves `ack`, `ramSel`, `extStrobe`, `addrHiOe`, `addrLoOe` and `badMode` low in the following cycle.
- R2: A synchronous active-high `rst` clears `ack`, `ramSel`, `extStrobe`, `addrHiOe`, `addrLoOe` and `badMode`.
- R3: The effective address is `dataPtr` when `wide` is 1, and `{pageReg, ptrLo}` when `wide` is 0.
- R4: With `mode` = 2'b00, every access selects the on-chip RAM, and `ramAddr` is the effective address modulo `RAM_BYTES`. For example, 0x1000 and 0x2000 both give 0.
- R5: With `mode` = 2'b01, an effective address below `RAM_BYTES` selects the on-chip RAM at that address, with `extStrobe` low.
- R6: With `mode` = 2'b01, a narrow access (`wide` = 0) at or above `RAM_BYTES` produces the following: `extStrobe` = 1, `addrLoOe` = 1, `addrHiOe` = 0, `extAddr[7:0]` = `ptrLo`, and `extAddr[15:8]` = 0.
- R7: With `mode` = 2'b01, a wide access at or above `RAM_BYTES` produces `extStrobe` = 1, both address enables high, and `extAddr` = `dataPtr`.
- R8: For an on-chip result, `extStrobe`, `addrHiOe` and `addrLoOe` are low and `extAddr` is 0. For an off-chip result, `ramSel` is low and `ramAddr` is 0.
- R9: A narrow access in split mode compares the whole of `{pageReg, ptrLo}` against the boundary. With the default 2048-byte RAM, page 0x07 with pointer 0xFF stays on chip, while page 0x08 with pointer 0x00 goes off chip.
- R10: `mode` values 2'b10 and 2'b11 route like 2'b00 and raise `badMode` alongside `ack`. Modes 2'b00 and 2'b01 leave `badMode` low.
- R11: Requests on consecutive cycles are each acknowledged, and each result reflects only its own request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle per access |
| wide | input | 1 | 1 = 16-bit data pointer addressing, 0 = 8-bit pointer addressing |
| ptrLo | input | 8 | Register-pointer byte (low address byte for 8-bit accesses) |
| dataPtr | input | 16 | 16-bit data pointer |
| pageReg | input | 8 | Page register (high address byte for 8-bit accesses) |
| mode | input | 2 | 00 internal-only, 01 split, 10/11 unsupported (treated as 00) |
| ack | output | 1 | One-cycle acknowledge, one cycle after the request |
| ramSel | output | 1 | On-chip RAM select |
| ramAddr | output | log2(RAM_BYTES) | On-chip RAM address |
| extStrobe | output | 1 | External bus access strobe |
| extAddr | output | 16 | External address bus value |
| addrHiOe | output | 1 | Drive enable for external address bits 15:8 |
| addrLoOe | output | 1 | Drive enable for external address bits 7:0 |
| badMode | output | 1 | Unsupported mode flag, valid with `ack` |

## Verification
The routing decision is exercised with addresses that sit on either side of the 2048-byte boundary, once through the data pointer and once through the page/pointer pair. This separates a comparison on the full effective address from one on only the low byte or only the page. Internal-only accesses use addresses that are multiples of 4 KB and 8 KB, plus a mid-range value, which shows whether the address is truncated to the RAM width or passed through unchanged. Narrow and wide off-chip accesses share similar addresses, so a mistake in the upper-byte drive enable or its data appears at the bus. Reserved modes, idle cycles and back-to-back requests show whether the flag and the acknowledge follow each request alone.

// File: rtl/xdr_pkg.sv
package xdr_pkg;

  typedef enum logic [1:0] {
    MODE_ONCHIP = 2'b00,
    MODE_SPLIT  = 2'b01,
    MODE_RSV2   = 2'b10,
    MODE_RSV3   = 2'b11
  } xdrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new access this cycle
    logic toExt;    // access leaves the chip
    logic driveHi;  // upper address byte is driven
  } xdrStrobe_t;

endpackage

// File: rtl/xdr_dpath.sv
module xdr_dpath
  import xdr_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic [7:0]        ptrLo,
  input  logic [15:0]       dataPtr,
  input  logic [7:0]        pageReg,
  input  xdrStrobe_t        strobe,
  output logic              aboveRam,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [15:0]       extAddr
);

  localparam logic [16:0] RAM_LIMIT = 17'(RAM_BYTES);

  logic [15:0]       effAddr;
  logic [RAM_AW-1:0] ramAddrQ;
  logic [15:0]       extAddrQ;
  logic [15:0]       extAddrNext;

  always_comb begin
    effAddr  = wide ? dataPtr : {pageReg, ptrLo};
    aboveRam = ({1'b0, effAddr} >= RAM_LIMIT);
  end

  // upper byte is forced to zero whenever it is not driven
  always_comb begin
    extAddrNext = {8'h00, effAddr[7:0]};
    if (strobe.driveHi) extAddrNext[15:8] = effAddr[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ramAddrQ <= '0;
      extAddrQ <= '0;
    end else if (strobe.load) begin
      if (strobe.toExt) begin
        ramAddrQ <= '0;
        extAddrQ <= extAddrNext;
      end else begin
        ramAddrQ <= effAddr[RAM_AW-1:0];
        extAddrQ <= '0;
      end
    end
  end

  assign ramAddr = ramAddrQ;
  assign extAddr = extAddrQ;

endmodule

// File: rtl/xdr_ctrl.sv
module xdr_ctrl
  import xdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       wide,
  input  logic [1:0] mode,
  input  logic       aboveRam,
  output xdrStrobe_t strobe,
  output logic       ack,
  output logic       ramSel,
  output logic       extStrobe,
  output logic       addrHiOe,
  output logic       addrLoOe,
  output logic       badMode
);

  xdrMode_e modeSel;
  logic     goExt;
  logic     unsupported;
  logic     ackQ, ramSelQ, extQ, hiQ, loQ, badQ;

  always_comb begin
    modeSel     = xdrMode_e'(mode);
    unsupported = (modeSel == MODE_RSV2) || (modeSel == MODE_RSV3);
    goExt       = (modeSel == MODE_SPLIT) && aboveRam;
    strobe.load    = req;
    strobe.toExt   = goExt;
    strobe.driveHi = goExt && wide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackQ    <= 1'b0;
      ramSelQ <= 1'b0;
      extQ    <= 1'b0;
      hiQ     <= 1'b0;
      loQ     <= 1'b0;
      badQ    <= 1'b0;
    end else begin
      ackQ    <= req;
      ramSelQ <= req && !goExt;
      extQ    <= req && goExt;
      hiQ     <= req && goExt && wide;
      loQ     <= req && goExt;
      badQ    <= req && unsupported;
    end
  end

  assign ack       = ackQ;
  assign ramSel    = ramSelQ;
  assign extStrobe = extQ;
  assign addrHiOe  = hiQ;
  assign addrLoOe  = loQ;
  assign badMode   = badQ;

endmodule

// File: rtl/xdataRouter.sv
module xdataRouter
  import xdr_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wide,
  input  logic [7:0]        ptrLo,
  input  logic [15:0]       dataPtr,
  input  logic [7:0]        pageReg,
  input  logic [1:0]        mode,
  output logic              ack,
  output logic              ramSel,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              extStrobe,
  output logic [15:0]       extAddr,
  output logic              addrHiOe,
  output logic              addrLoOe,
  output logic              badMode
);

  xdrStrobe_t strobe;
  logic       aboveRam;

  xdr_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .wide     (wide),
    .mode     (mode),
    .aboveRam (aboveRam),
    .strobe   (strobe),
    .ack      (ack),
    .ramSel   (ramSel),
    .extStrobe(extStrobe),
    .addrHiOe (addrHiOe),
    .addrLoOe (addrLoOe),
    .badMode  (badMode)
  );

  xdr_dpath #(.RAM_BYTES(RAM_BYTES)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .wide    (wide),
    .ptrLo   (ptrLo),
    .dataPtr (dataPtr),
    .pageReg (pageReg),
    .strobe  (strobe),
    .aboveRam(aboveRam),
    .ramAddr (ramAddr),
    .extAddr (extAddr)
  );

endmodule

// File: rtl/xdr_checker.sv
module xdr_checker #(
  parameter int RAM_BYTES = 2048,
  localparam int RAM_AW = $clog2(RAM_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              wide,
  input logic [7:0]        ptrLo,
  input logic [15:0]       dataPtr,
  input logic [7:0]        pageReg,
  input logic [1:0]        mode,
  input logic              ack,
  input logic              ramSel,
  input logic [RAM_AW-1:0] ramAddr,
  input logic              extStrobe,
  input logic [15:0]       extAddr,
  input logic              addrHiOe,
  input logic              addrLoOe,
  input logic              badMode
);

  localparam logic [16:0] LIMIT = 17'(RAM_BYTES);
  logic [15:0] narrowEa;
  logic        narrowOff, wideOff;

  always_comb begin
    narrowEa  = {pageReg, ptrLo};
    narrowOff = req && !wide && (mode == 2'b01) && ({1'b0, narrowEa} >= LIMIT);
    wideOff   = req && wide && (mode == 2'b01) && ({1'b0, dataPtr} >= LIMIT);
  end

  a_r1_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> ack);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ack && !ramSel && !extStrobe && !addrHiOe && !addrLoOe && !badMode);
  a_r4_onchip_wrap: assert property (@(posedge clk) disable iff (rst)
    req && wide && mode == 2'b00 |=> ramSel && ramAddr == $past(dataPtr[RAM_AW-1:0]));
  a_r6_narrow_off: assert property (@(posedge clk) disable iff (rst)
    narrowOff |=> extStrobe && addrLoOe && !addrHiOe && extAddr == {8'h00, $past(ptrLo)});
  a_r7_wide_off: assert property (@(posedge clk) disable iff (rst)
    wideOff |=> extStrobe && addrHiOe && addrLoOe && extAddr == $past(dataPtr));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ramSel && extStrobe));
  a_r8_oe_only_ext: assert property (@(posedge clk) disable iff (rst)
    !extStrobe |-> !addrHiOe && !addrLoOe);
  a_r10_bad_flag: assert property (@(posedge clk) disable iff (rst)
    req |=> badMode == $past(mode[1]));

endmodule

bind xdataRouter xdr_checker #(.RAM_BYTES(RAM_BYTES)) u_xdrChecker (
  .clk(clk), .rst(rst), .req(req), .wide(wide), .ptrLo(ptrLo),
  .dataPtr(dataPtr), .pageReg(pageReg), .mode(mode), .ack(ack),
  .ramSel(ramSel), .ramAddr(ramAddr), .extStrobe(extStrobe),
  .extAddr(extAddr), .addrHiOe(addrHiOe), .addrLoOe(addrLoOe),
  .badMode(badMode)
);

// File: tb/test_xdataRouter.sv
module test_xdataRouter;

  localparam int RB = 2048;
  localparam int AW = $clog2(RB);

  logic          clk = 1'b0;
  logic          rst;
  logic          req;
  logic          wide;
  logic [7:0]    ptrLo;
  logic [15:0]   dataPtr;
  logic [7:0]    pageReg;
  logic [1:0]    mode;
  logic          ack, ramSel, extStrobe, addrHiOe, addrLoOe, badMode;
  logic [AW-1:0] ramAddr;
  logic [15:0]   extAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  xdataRouter #(.RAM_BYTES(RB)) i_xdataRouter (
    .clk(clk), .rst(rst), .req(req), .wide(wide), .ptrLo(ptrLo),
    .dataPtr(dataPtr), .pageReg(pageReg), .mode(mode), .ack(ack),
    .ramSel(ramSel), .ramAddr(ramAddr), .extStrobe(extStrobe),
    .extAddr(extAddr), .addrHiOe(addrHiOe), .addrLoOe(addrLoOe),
    .badMode(badMode)
  );

  // compare all outputs as one check
  task automatic expectOut(string tag, bit eAck, bit eRam, logic [AW-1:0] eRamAddr,
                           bit eExt, logic [15:0] eExtAddr, bit eHi, bit eLo, bit eBad);
    logic [AW+22:0] act, exp;
    act = {ack, ramSel, ramAddr, extStrobe, extAddr, addrHiOe, addrLoOe, badMode};
    exp = {eAck, eRam, eRamAddr, eExt, eExtAddr, eHi, eLo, eBad};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ack/ramSel/ramAddr/ext/extAddr/hi/lo/bad actual %0b/%0b/%h/%0b/%h/%0b/%0b/%0b expected %0b/%0b/%h/%0b/%h/%0b/%0b/%0b",
               tag, ack, ramSel, ramAddr, extStrobe, extAddr, addrHiOe, addrLoOe, badMode,
               eAck, eRam, eRamAddr, eExt, eExtAddr, eHi, eLo, eBad);
    end
  endtask

  // drive one request at a negedge; results visible after the next posedge
  task automatic issue(bit w, logic [1:0] m, logic [7:0] pg, logic [7:0] pl, logic [15:0] dp);
    req = 1'b1; wide = w; mode = m; pageReg = pg; ptrLo = pl; dataPtr = dp;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    expectOut("R2 reset state", 0, 0, '0, 0, 16'h0, 0, 0, 0);
  endtask

  task automatic testInternal();
    issue(1, 2'b00, 8'h00, 8'h00, 16'h1000);
    expectOut("R4 wrap 0x1000", 1, 1, '0, 0, 16'h0, 0, 0, 0);
    issue(1, 2'b00, 8'h00, 8'h00, 16'h2000);
    expectOut("R4 wrap 0x2000", 1, 1, '0, 0, 16'h0, 0, 0, 0);
    issue(1, 2'b00, 8'h00, 8'h00, 16'h0ABC);
    expectOut("R4 R8 mask 0x0ABC", 1, 1, AW'(16'h02BC), 0, 16'h0, 0, 0, 0);
    issue(0, 2'b00, 8'h12, 8'h34, 16'hFFFF);
    expectOut("R3 narrow page 0x12 ptr 0x34", 1, 1, AW'(16'h0234), 0, 16'h0, 0, 0, 0);
  endtask

  task automatic testSplit();
    issue(1, 2'b01, 8'hFF, 8'hFF, 16'h07FF);
    expectOut("R5 wide 0x07FF on chip", 1, 1, AW'(16'h07FF), 0, 16'h0, 0, 0, 0);
    issue(1, 2'b01, 8'h00, 8'h00, 16'h0800);
    expectOut("R7 wide 0x0800 off chip", 1, 0, '0, 1, 16'h0800, 1, 1, 0);
    issue(1, 2'b01, 8'h00, 8'h11, 16'hBEEF);
    expectOut("R7 R3 wide 0xBEEF", 1, 0, '0, 1, 16'hBEEF, 1, 1, 0);
    issue(0, 2'b01, 8'hC3, 8'h5A, 16'h0000);
    expectOut("R6 narrow off chip", 1, 0, '0, 1, 16'h005A, 0, 1, 0);
  endtask

  task automatic testBoundary();
    issue(0, 2'b01, 8'h07, 8'hFF, 16'hFFFF);
    expectOut("R9 page 07 ptr FF on chip", 1, 1, AW'(16'h07FF), 0, 16'h0, 0, 0, 0);
    issue(0, 2'b01, 8'h08, 8'h00, 16'h0000);
    expectOut("R9 page 08 ptr 00 off chip", 1, 0, '0, 1, 16'h0000, 0, 1, 0);
  endtask

  task automatic testReserved();
    issue(1, 2'b10, 8'h00, 8'h00, 16'h1800);
    expectOut("R10 mode 10", 1, 1, '0, 0, 16'h0, 0, 0, 1);
    issue(0, 2'b11, 8'h40, 8'h11, 16'h0000);
    expectOut("R10 mode 11 narrow", 1, 1, AW'(16'h0011), 0, 16'h0, 0, 0, 1);
  endtask

  task automatic testIdle();
    @(posedge clk);
    @(negedge clk);
    expectOut("R1 idle quiet", 0, ramSel ? 1'b1 : 1'b0, ramAddr, 0, extAddr, 0, 0, 0);
    checks++;
    if (ramSel !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle ramSel actual %0b expected 0", ramSel);
    end
  endtask

  task automatic testBackToBack();
    req = 1'b1; wide = 1'b1; mode = 2'b01; pageReg = 8'h00; ptrLo = 8'h00; dataPtr = 16'h9000;
    @(posedge clk);
    @(negedge clk);
    expectOut("R11 first of pair", 1, 0, '0, 1, 16'h9000, 1, 1, 0);
    wide = 1'b0; mode = 2'b10; pageReg = 8'h01; ptrLo = 8'h23;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    expectOut("R11 second of pair", 1, 1, AW'(16'h0123), 0, 16'h0, 0, 0, 1);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (ack !== 1'b0 || badMode !== 1'b0) begin
      fails++;
      $display("FAIL R1 ack after pair actual %0b/%0b expected 0/0", ack, badMode);
    end
  endtask

  initial begin
    rst = 1'b1; req = 1'b0; wide = 1'b0; ptrLo = '0; dataPtr = '0; pageReg = '0; mode = '0;
    repeat (3) @(posedge clk);
    testReset();
    rst = 1'b0;
    testInternal();
    testSplit();
    testBoundary();
    testReserved();
    testIdle();
    testBackToBack();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule